// File: doc/BRIEF.md
# Slow-Clock Period Counter in a Fast Clock Domain

This block measures the period of a slow, independent clock in units of a faster clock. Each slow rising edge inverts one flip-flop in the slow domain, and that single bit is the only thing that crosses into the fast domain. There it is shifted through a chain of flip-flops. Whenever the two oldest stages of the chain disagree, a slow edge has been seen.

On each detected edge, the running fast-cycle count is latched into the output and the counter restarts from zero. In every other fast cycle the counter advances by one. Detection lags the real slow edge by a fixed number of fast cycles, so the timing is constant from one edge to the next.

All actions on the count are taken on the fast clock alone. The slow clock never reaches the clock, reset or enable of the counter. When the slow clock stops, the count saturates, so a stalled slow clock shows up as the maximum count value.

Top module: `slow_edge_counter`

## Requirements
- R1: After a slow rising edge, valid_o is high in the cycle that follows the SYNC_LEN-th fast rising edge after that slow edge (default SYNC_LEN = 9).
- R2: When the slow period is a steady N fast cycles, each reported count_o equals N-1.
- R3: valid_o is a pulse exactly one fast cycle wide, with one pulse per detected slow edge. No pulse is missed and none is extra.
- R4: count_o changes only in a cycle where valid_o is high, and holds its value between captures.
- R5: The counter stops at 2^CNT_W-1 (65535 by default) instead of wrapping. A slow gap longer than that is reported as 65535.
- R6: While fast_rst_n is low, count_o is 0 and valid_o is 0.
- R7: No valid_o pulse occurs during the first SYNC_LEN fast cycles after fast_rst_n is released. This holds even when the slow-domain toggle already differs from its reset value.
- R8: In a cycle without a detected edge, the internal counter increases by exactly one, unless it is saturated. In the cycle a capture is reported, the counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast measurement clock |
| fast_rst_n | input | 1 | Asynchronous active-low reset for the fast domain |
| slow_clk | input | 1 | Slow clock whose period is measured |
| slow_rst_n | input | 1 | Asynchronous active-low reset for the slow domain toggle |
| count_o | output | CNT_W | Last captured period, in fast cycles minus one |
| valid_o | output | 1 | One-cycle strobe marking a new count_o |

## Verification
A capture for a slow edge is due SYNC_LEN fast edges after that slow edge. At that point count_o shows the length of the interval that the edge closed. The bench drives each slow edge itself and pushes the expected count for the interval just closed into a queue. It also counts fast edges since the last slow edge, and at each strobe it checks that this count equals SYNC_LEN whenever the slow period is longer than the shift chain. Outputs are sampled on the falling fast edge, midway between the registers updating, so every comparison sees the value settled after the edge that produced it.

// File: rtl/slow_edge_counter.sv
module slow_edge_counter #(
  parameter int CNT_W    = 16,
  parameter int SYNC_LEN = 9
) (
  input  logic             fast_clk,
  input  logic             fast_rst_n,
  input  logic             slow_clk,
  input  logic             slow_rst_n,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int FILL_W = $clog2(SYNC_LEN + 1);

  logic                slow_tgl;
  logic [SYNC_LEN-1:0] tap;
  logic [CNT_W-1:0]    cnt;
  logic [FILL_W-1:0]   fill;
  logic                seen;
  logic                filled;

  always_ff @(posedge slow_clk or negedge slow_rst_n)
    if (!slow_rst_n) slow_tgl <= 1'b0;
    else             slow_tgl <= ~slow_tgl;

  assign seen   = tap[SYNC_LEN-1] ^ tap[SYNC_LEN-2];
  assign filled = (fill == FILL_W'(SYNC_LEN));

  always_ff @(posedge fast_clk or negedge fast_rst_n)
    if (!fast_rst_n) begin
      tap     <= '0;
      fill    <= '0;
      cnt     <= '0;
      count_o <= '0;
      valid_o <= 1'b0;
    end else begin
      tap     <= {tap[SYNC_LEN-2:0], slow_tgl};
      if (!filled) fill <= fill + 1'b1;
      valid_o <= seen & filled;
      if (seen) begin
        cnt <= '0;
        if (filled) count_o <= cnt;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end

  a_r8_cleared_on_capture: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    valid_o |-> cnt == '0);

  a_r8_increments: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    ($past(filled) && !valid_o && $past(cnt) != CNT_MAX && cnt != '0) |-> cnt == $past(cnt) + 1'b1);

  a_r5_no_wrap: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX || cnt == '0));

  a_r4_hold: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    !valid_o |-> $stable(count_o));

  a_r7_no_early_valid: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    valid_o |-> filled);

endmodule

// File: tb/slow_edge_counter_bench.sv
module slow_edge_counter_bench;
  localparam int L    = 9;
  localparam int CW   = 16;
  localparam int MAXC = 65535;

  logic fast_clk = 1'b0, slow_clk = 1'b0;
  logic fast_rst_n = 1'b0, slow_rst_n = 1'b0;
  logic [CW-1:0] count_o;
  logic valid_o;

  slow_edge_counter #(.CNT_W(CW), .SYNC_LEN(L)) u_slow_edge_counter (
    .fast_clk(fast_clk), .fast_rst_n(fast_rst_n),
    .slow_clk(slow_clk), .slow_rst_n(slow_rst_n),
    .count_o(count_o), .valid_o(valid_o));

  always #5 fast_clk = ~fast_clk;

  int checks = 0, fails = 0;
  int q[$];
  int since = 0, prev_p = 0, e = 0, nv = 0, r4_viol = 0;
  bit lat_en = 0, mon_en = 0, last_v = 0;
  logic [CW-1:0] last_cnt = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge slow_clk) since = 0;
  always @(posedge fast_clk) since++;

  // driver: one slow cycle of period p (ns); pushes the expected count of the interval just closed
  task automatic pulse(input int p);
    int exp;
    slow_clk = 1'b1;
    if (prev_p == 0) q.push_back(-1);
    else begin
      exp = prev_p / 10 - 1;
      q.push_back(exp > MAXC ? MAXC : exp);
    end
    prev_p = p;
    #(p / 2) slow_clk = 1'b0;
    #(p - p / 2);
  endtask

  // monitor / scoreboard
  always @(negedge fast_clk) if (mon_en) begin
    if (valid_o) begin
      if (q.size() == 0) chk(0, "R3 extra pulse", 1, 0);
      else begin
        e = q.pop_front();
        if (e >= 0) chk(int'(count_o) == e, (e == MAXC) ? "R5 saturated count" : "R2 period count", int'(count_o), e);
      end
      if (lat_en) chk(since == L, "R1 detection latency", since, L);
      if (last_v) chk(0, "R3 pulse width", 2, 1);
    end else if (count_o != last_cnt) begin
      r4_viol++;
      chk(0, "R4 hold", int'(count_o), int'(last_cnt));
    end
    last_cnt = count_o;
    last_v   = valid_o;
  end

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge fast_clk);
    chk(count_o == '0, "R6 count in reset", int'(count_o), 0);
    chk(valid_o == 1'b0, "R6 valid in reset", int'(valid_o), 0);
    slow_rst_n = 1'b1;
    #20 slow_clk = 1'b1;
    #20 slow_clk = 1'b0;
    @(negedge fast_clk) fast_rst_n = 1'b1;
    repeat (L + 4) begin
      @(negedge fast_clk);
      if (valid_o) nv++;
    end
    chk(nv == 0, "R7 no valid while filling", nv, 0);
    last_cnt = count_o;
    mon_en = 1;
    lat_en = 1;
    @(posedge fast_clk);
    #3;
    repeat (6) pulse(100);
    lat_en = 0;
    repeat (6) pulse(70);
    pulse(700000);
    lat_en = 1;
    repeat (5) pulse(130);
    repeat (L + 5) @(negedge fast_clk);
    chk(q.size() == 0, "R3 every edge reported", q.size(), 0);
    chk(r4_viol == 0, "R4 no change between captures", r4_viol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule